// File: doc/BRIEF.md
# Rectangle Pixel Transfer Engine

This block moves a rectangular patch of 16-bit pixels between a processor-side word port and a synchronous pixel memory organised as a grid of 2^X_W columns by 2^Y_W rows. Its defaults give 1024 by 512 pixels. A single start pulse loads three values: an opcode that selects the direction, a position word holding the top-left corner, and a size word holding the width and height. From then on the engine walks the rectangle left to right, one row after the next. Each 32-bit word on the processor side carries two pixels. On a write the engine splits each incoming word into two memory writes. On a read it issues two memory reads and returns them packed into one word.

The processor side may leave any number of idle cycles between words. The engine keeps its place in the rectangle across such gaps, including a position in the middle of a row. It does the same when a row ends between the two pixels of one word. While pixels remain to be moved, a busy flag stays high. A start that arrives while that flag is high throws away the old transfer and sets a sticky flag.

Top module: `rect_xfer_engine`

## Requirements
- R1: The column start is position bits [X_W-1:0] and the row start is position bits [16+Y_W-1:16]. All other position bits are ignored.
- R2: The width is size bits [X_W-1:0] and the height is size bits [16+Y_W-1:16]. A field of zero means the full extent (2^X_W columns or 2^Y_W rows). All other size bits are ignored.
- R3: Pixel k of the transfer, counted from 0, goes to memory address row*2^X_W + col. Here col = (x0 + k mod w) mod 2^X_W and row = (y0 + k div w) mod 2^Y_W. Both coordinates wrap at the array edge.
- R4: A transfer is a read when opcode bits [7:5] equal 3'b110, and a write for every other opcode. In a write transfer wr_ready_o is high while the engine waits for a word. In a read transfer it is low.
- R5: On a write, a word accepted at a clock edge (wr_valid_i and wr_ready_o both high) is written as two pixels, bits [15:0] first and then bits [31:16]. These writes fall on consecutive pixel positions in the next two cycles. wr_ready_o rises again two cycles after the edge that accepted the word.
- R6: On a read, a request accepted at a clock edge (rd_req_i high while the engine waits) yields rd_valid_o for exactly one cycle, starting three edges later. rd_word_o then holds the lower-positioned pixel in bits [15:0] and the next pixel in bits [31:16].
- R7: Gaps between words leave the position within the rectangle unchanged, and the next word continues from the pixel offset reached, mid-row or not. The memory address is stable while no pixel is moved.
- R8: busy_o rises on the edge that takes start_i and falls after the last pixel of the rectangle. When the pixel count is odd, the upper half of the final write word is discarded, and the upper half of the final read word is zero.
- R9: start_i while busy_o is high cancels the old transfer and begins the new one. It also sets anomaly_o, which then stays high until reset.
- R10: Write words offered during a read transfer, and read requests during a write transfer, have no effect on memory or on rd_valid_o.
- R11: After reset busy_o, anomaly_o, wr_ready_o, rd_valid_o, mem_we_o and mem_re_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load a new transfer from opcode_i, pos_i and size_i |
| opcode_i | input | 8 | Command code; selects read or write |
| pos_i | input | 32 | Top-left corner: column in low bits, row from bit 16 |
| size_i | input | 32 | Width in low bits, height from bit 16 |
| wr_valid_i | input | 1 | Write word offered |
| wr_word_i | input | 2*PIX_W | Two pixels to write, lower position in low half |
| wr_ready_o | output | 1 | Engine takes a write word at this edge |
| rd_req_i | input | 1 | Request the next read word |
| rd_valid_o | output | 1 | rd_word_o holds a finished read word |
| rd_word_o | output | 2*PIX_W | Two pixels read, lower position in low half |
| mem_we_o | output | 1 | Pixel memory write strobe |
| mem_re_o | output | 1 | Pixel memory read strobe; data appears one cycle later |
| mem_addr_o | output | X_W+Y_W | Pixel address {row, column} |
| mem_wdata_o | output | PIX_W | Pixel to write |
| mem_rdata_i | input | PIX_W | Pixel read, one cycle after mem_re_o |
| busy_o | output | 1 | Transfer in progress |
| anomaly_o | output | 1 | Sticky: a transfer was restarted while busy |

## Verification
The bench builds the engine with X_W = 3 and Y_W = 2, an 8 by 4 pixel array. With that size every start column, start row, width field and height field can be combined in both directions: 1024 write and 1024 read transfers. These cover zero fields meaning full extent, wrap across both edges, and odd pixel counts that end mid-word. Junk in the unused position and size bits, random-length gaps between words, and traffic in the wrong direction are mixed into the same sweeps. All 256 opcodes are tried for direction selection, and a restart while busy checks the sticky flag and the abort of the old transfer.

// File: rtl/rect_xfer_pkg.sv
package rect_xfer_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PIX0 = 2'd1,
    SEQ_PIX1 = 2'd2,
    SEQ_CAP  = 2'd3
  } seq_state_e;

  // opcode bits [7:5] that select a memory-to-host transfer
  localparam logic [2:0] RD_OP_TAG = 3'b110;

  localparam int unsigned ROW_FIELD_LSB = 16;

endpackage

// File: rtl/rect_xfer_decode.sv
module rect_xfer_decode
  import rect_xfer_pkg::*;
#(
  parameter int unsigned X_W = 10,
  parameter int unsigned Y_W = 9
) (
  input  logic [7:0]   opcode_i,
  input  logic [31:0]  pos_i,
  input  logic [31:0]  size_i,
  output logic [X_W-1:0] x0_o,
  output logic [Y_W-1:0] y0_o,
  output logic [X_W:0]   w_o,
  output logic [Y_W:0]   h_o,
  output logic           rd_o
);

  localparam int unsigned YL = ROW_FIELD_LSB;

  logic [X_W-1:0] w_fld;
  logic [Y_W-1:0] h_fld;

  assign x0_o  = pos_i[X_W-1:0];
  assign y0_o  = pos_i[YL +: Y_W];
  assign w_fld = size_i[X_W-1:0];
  assign h_fld = size_i[YL +: Y_W];

  // zero field means full extent: ((f - 1) & mask) + 1
  assign w_o  = {(w_fld == '0), w_fld};
  assign h_o  = {(h_fld == '0), h_fld};
  assign rd_o = (opcode_i[7:5] == RD_OP_TAG);

  logic unused_bits;
  assign unused_bits = ^{opcode_i[4:0], pos_i[YL-1:X_W], pos_i[31:YL+Y_W],
                         size_i[YL-1:X_W], size_i[31:YL+Y_W]};

endmodule

// File: rtl/rect_xfer_walker.sv
module rect_xfer_walker #(
  parameter int unsigned X_W = 10,
  parameter int unsigned Y_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [X_W-1:0]     x0_i,
  input  logic [Y_W-1:0]     y0_i,
  input  logic [X_W:0]       w_i,
  input  logic [Y_W:0]       h_i,
  input  logic               step_i,
  output logic [X_W+Y_W-1:0] addr_o,
  output logic               busy_o
);

  logic [X_W-1:0] x0_q;
  logic [Y_W-1:0] y_q;
  logic [X_W-1:0] col_q;
  logic [X_W:0]   w_q;
  logic [Y_W:0]   h_q;
  logic           row_end;

  assign row_end = ({1'b0, col_q} == (w_q - (X_W+1)'(1)));
  assign busy_o  = (h_q != '0);
  assign addr_o  = {y_q, x0_q + col_q};  // X_W-bit sum wraps the column

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x0_q  <= '0;
      y_q   <= '0;
      col_q <= '0;
      w_q   <= '0;
      h_q   <= '0;
    end else if (load_i) begin
      x0_q  <= x0_i;
      y_q   <= y0_i;
      col_q <= '0;
      w_q   <= w_i;
      h_q   <= h_i;
    end else if (step_i && busy_o) begin
      if (row_end) begin
        col_q <= '0;
        y_q   <= y_q + Y_W'(1);
        h_q   <= h_q - (Y_W+1)'(1);
      end else begin
        col_q <= col_q + X_W'(1);
      end
    end
  end

endmodule

// File: rtl/rect_xfer_seq.sv
module rect_xfer_seq
  import rect_xfer_pkg::*;
#(
  parameter int unsigned PIX_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               busy_i,
  input  logic               rd_mode_i,
  input  logic               wr_valid_i,
  input  logic [2*PIX_W-1:0] wr_word_i,
  output logic               wr_ready_o,
  input  logic               rd_req_i,
  output logic               rd_valid_o,
  output logic [2*PIX_W-1:0] rd_word_o,
  input  logic [PIX_W-1:0]   mem_rdata_i,
  output logic               pix_we_o,
  output logic               pix_re_o,
  output logic [PIX_W-1:0]   pix_wdata_o,
  output logic               step_o
);

  seq_state_e           st_q;
  logic [PIX_W-1:0]     lane_q [2];
  logic                 hi_ok_q;
  logic                 idle;
  logic                 acc_wr;
  logic                 acc_rd;
  logic                 pix_act;
  logic                 sel_hi;

  assign idle       = (st_q == SEQ_IDLE);
  assign wr_ready_o = idle && busy_i && !rd_mode_i;
  assign acc_wr     = wr_ready_o && wr_valid_i;
  assign acc_rd     = idle && busy_i && rd_mode_i && rd_req_i;
  assign pix_act    = ((st_q == SEQ_PIX0) || (st_q == SEQ_PIX1)) && busy_i;
  assign sel_hi     = (st_q == SEQ_PIX1);
  assign pix_we_o   = pix_act && !rd_mode_i;
  assign pix_re_o   = pix_act && rd_mode_i;
  assign step_o     = pix_act;
  assign pix_wdata_o = lane_q[sel_hi];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SEQ_IDLE;
      lane_q[0]  <= '0;
      lane_q[1]  <= '0;
      hi_ok_q    <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_word_o  <= '0;
    end else begin
      rd_valid_o <= 1'b0;
      if (start_i) begin
        st_q <= SEQ_IDLE;
      end else begin
        unique case (st_q)
          SEQ_IDLE: begin
            if (acc_wr) begin
              lane_q[0] <= wr_word_i[PIX_W-1:0];
              lane_q[1] <= wr_word_i[2*PIX_W-1:PIX_W];
            end
            if (acc_wr || acc_rd) st_q <= SEQ_PIX0;
          end
          SEQ_PIX0: st_q <= SEQ_PIX1;
          SEQ_PIX1: begin
            hi_ok_q <= busy_i;
            if (rd_mode_i) begin
              lane_q[0] <= mem_rdata_i;  // data for the read issued in PIX0
              st_q      <= SEQ_CAP;
            end else begin
              st_q <= SEQ_IDLE;
            end
          end
          SEQ_CAP: begin
            rd_word_o  <= {(hi_ok_q ? mem_rdata_i : {PIX_W{1'b0}}), lane_q[0]};
            rd_valid_o <= 1'b1;
            st_q       <= SEQ_IDLE;
          end
          default: st_q <= SEQ_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rect_xfer_engine.sv
module rect_xfer_engine
  import rect_xfer_pkg::*;
#(
  parameter int unsigned X_W   = 10,
  parameter int unsigned Y_W   = 9,
  parameter int unsigned PIX_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [7:0]           opcode_i,
  input  logic [31:0]          pos_i,
  input  logic [31:0]          size_i,
  input  logic                 wr_valid_i,
  input  logic [2*PIX_W-1:0]   wr_word_i,
  output logic                 wr_ready_o,
  input  logic                 rd_req_i,
  output logic                 rd_valid_o,
  output logic [2*PIX_W-1:0]   rd_word_o,
  output logic                 mem_we_o,
  output logic                 mem_re_o,
  output logic [X_W+Y_W-1:0]   mem_addr_o,
  output logic [PIX_W-1:0]     mem_wdata_o,
  input  logic [PIX_W-1:0]     mem_rdata_i,
  output logic                 busy_o,
  output logic                 anomaly_o
);

  logic [X_W-1:0] dec_x0;
  logic [Y_W-1:0] dec_y0;
  logic [X_W:0]   dec_w;
  logic [Y_W:0]   dec_h;
  logic           dec_rd;
  logic           rd_mode_q;
  logic           step;

  rect_xfer_decode #(.X_W(X_W), .Y_W(Y_W)) u_decode (
    .opcode_i (opcode_i),
    .pos_i    (pos_i),
    .size_i   (size_i),
    .x0_o     (dec_x0),
    .y0_o     (dec_y0),
    .w_o      (dec_w),
    .h_o      (dec_h),
    .rd_o     (dec_rd)
  );

  rect_xfer_walker #(.X_W(X_W), .Y_W(Y_W)) u_walker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .x0_i   (dec_x0),
    .y0_i   (dec_y0),
    .w_i    (dec_w),
    .h_i    (dec_h),
    .step_i (step),
    .addr_o (mem_addr_o),
    .busy_o (busy_o)
  );

  rect_xfer_seq #(.PIX_W(PIX_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_i      (busy_o),
    .rd_mode_i   (rd_mode_q),
    .wr_valid_i  (wr_valid_i),
    .wr_word_i   (wr_word_i),
    .wr_ready_o  (wr_ready_o),
    .rd_req_i    (rd_req_i),
    .rd_valid_o  (rd_valid_o),
    .rd_word_o   (rd_word_o),
    .mem_rdata_i (mem_rdata_i),
    .pix_we_o    (mem_we_o),
    .pix_re_o    (mem_re_o),
    .pix_wdata_o (mem_wdata_o),
    .step_o      (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_mode_q <= 1'b0;
      anomaly_o <= 1'b0;
    end else if (start_i) begin
      rd_mode_q <= dec_rd;
      if (busy_o) anomaly_o <= 1'b1;
    end
  end

endmodule

// File: rtl/rect_xfer_engine_chk.sv
module rect_xfer_engine_chk #(
  parameter int unsigned AW = 19
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          anomaly_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          rd_valid_o,
  input logic          rd_mode_i
);

  a_r10_no_write_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !rd_mode_i);

  a_r10_no_read_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> rd_mode_i);

  a_r5_strobes_need_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> busy_o);

  a_r9_anomaly_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    anomaly_o |=> anomaly_o);

  a_r9_anomaly_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(anomaly_o) |-> $past(start_i && busy_o));

  a_r8_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r8_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(mem_we_o || mem_re_o));

  a_r6_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  a_r7_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i && !mem_we_o && !mem_re_o) |=> $stable(mem_addr_o));

endmodule

bind rect_xfer_engine rect_xfer_engine_chk #(.AW(X_W + Y_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .anomaly_o  (anomaly_o),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .mem_addr_o (mem_addr_o),
  .rd_valid_o (rd_valid_o),
  .rd_mode_i  (rd_mode_q)
);

// File: tb/rect_xfer_engine_bench.sv
`timescale 1ns/1ps
module rect_xfer_engine_bench;

  localparam int XW = 3;
  localparam int YW = 2;
  localparam int PW = 16;
  localparam int NC = 1 << XW;
  localparam int NR = 1 << YW;
  localparam int NP = NC * NR;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    opcode = '0;
  logic [31:0]   pos = '0;
  logic [31:0]   size = '0;
  logic          wr_valid = 1'b0;
  logic [31:0]   wr_word = '0;
  logic          wr_ready;
  logic          rd_req = 1'b0;
  logic          rd_valid;
  logic [31:0]   rd_word;
  logic          mem_we, mem_re;
  logic [XW+YW-1:0] mem_addr;
  logic [PW-1:0] mem_wdata;
  logic [PW-1:0] mem_rdata = '0;
  logic          busy, anomaly;

  logic [PW-1:0] mem [NP];
  logic [PW-1:0] exp_mem [NP];

  int n_chk = 0;
  int n_fail = 0;
  int rv_seen = 0;
  bit watch_rv = 1'b0;

  always #10 clk = ~clk;

  rect_xfer_engine #(.X_W(XW), .Y_W(YW), .PIX_W(PW)) u_rect_xfer_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .pos_i(pos), .size_i(size), .wr_valid_i(wr_valid), .wr_word_i(wr_word),
    .wr_ready_o(wr_ready), .rd_req_i(rd_req), .rd_valid_o(rd_valid),
    .rd_word_o(rd_word), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .anomaly_o(anomaly)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) if (watch_rv && rd_valid) rv_seen++;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int addr_of(int x0, int y0, int w, int k);
    return (((y0 + k / w) % NR) * NC) + ((x0 + k % w) % NC);
  endfunction

  function automatic logic [PW-1:0] pv(int k, int s);
    return PW'(k * 311 + s * 97 + 5);
  endfunction

  function automatic logic [PW-1:0] pat(int a);
    return PW'(a * 16'h0101) ^ 16'h3c00;
  endfunction

  task automatic fill_pat();
    for (int i = 0; i < NP; i++) begin
      mem[i] = pat(i);
      exp_mem[i] = pat(i);
    end
  endtask

  function automatic int mem_miss();
    int m = 0;
    for (int i = 0; i < NP; i++) if (mem[i] !== exp_mem[i]) m++;
    return m;
  endfunction

  task automatic do_start(input logic [7:0] op, input logic [31:0] p,
                          input logic [31:0] s);
    @(negedge clk);
    start = 1'b1; opcode = op; pos = p; size = s;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] d, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_word = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic get_word(output logic [31:0] w, output bit early, output bit vld);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    early = rd_valid;
    @(negedge clk);
    vld = rd_valid;
    w = rd_word;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed = 0;
    logic [31:0] w;
    bit early, vld;
    fill_pat();
    do_reset();

    // R11 reset state
    chk(!busy && !anomaly, "R11 busy/anomaly after reset", {busy, anomaly}, 0);
    chk(!wr_ready && !rd_valid && !mem_we && !mem_re, "R11 strobes after reset",
        {wr_ready, rd_valid, mem_we, mem_re}, 0);

    // write sweep: R1 R2 R3 R5 R7 R8, with reads requested throughout (R10)
    rd_req = 1'b1;
    watch_rv = 1'b1;
    for (int xs = 0; xs < NC; xs++)
      for (int ys = 0; ys < NR; ys++)
        for (int wf = 0; wf < NC; wf++)
          for (int hf = 0; hf < NR; hf++) begin
            int wd, ht, n, nw;
            wd = (wf == 0) ? NC : wf;
            ht = (hf == 0) ? NR : hf;
            n  = wd * ht;
            nw = (n + 1) / 2;
            seed++;
            fill_pat();
            do_start(8'hA0 ^ 8'(seed & 8'h1f),
                     32'hFFFC_FFF8 | (ys << 16) | xs,
                     32'hFFFC_FFF8 | (hf << 16) | wf);
            chk(busy && wr_ready, "R8 R4 busy and ready after write start",
                {busy, wr_ready}, 2'b11);
            for (int j = 0; j < nw; j++) begin
              send_word({pv(2*j+1, seed), pv(2*j, seed)}, (j + xs) % 3);
              exp_mem[addr_of(xs, ys, wd, 2*j)] = pv(2*j, seed);
              if (2*j + 1 < n) exp_mem[addr_of(xs, ys, wd, 2*j+1)] = pv(2*j+1, seed);
            end
            @(negedge clk);
            @(negedge clk);
            chk(!busy, "R8 busy low after last write pixel", busy, 0);
            chk(mem_miss() == 0, "R3 R5 R7 written rectangle", mem_miss(), 0);
          end
    rd_req = 1'b0;
    watch_rv = 1'b0;
    chk(rv_seen == 0, "R10 read requests ignored in write mode", rv_seen, 0);

    // read sweep: R3 R6 R8, with write words offered throughout (R10)
    fill_pat();
    wr_word = 32'hDEAD_BEEF;
    wr_valid = 1'b1;
    for (int xs = 0; xs < NC; xs++)
      for (int ys = 0; ys < NR; ys++)
        for (int wf = 0; wf < NC; wf++)
          for (int hf = 0; hf < NR; hf++) begin
            int wd, ht, n, nw, bad;
            logic [31:0] ew;
            wd = (wf == 0) ? NC : wf;
            ht = (hf == 0) ? NR : hf;
            n  = wd * ht;
            nw = (n + 1) / 2;
            bad = 0;
            seed++;
            do_start(8'hC0 | 8'(seed & 8'h1f),
                     32'hFFFC_FFF8 | (ys << 16) | xs,
                     32'hFFFC_FFF8 | (hf << 16) | wf);
            chk(busy && !wr_ready, "R4 read mode busy, not ready for words",
                {busy, wr_ready}, 2'b10);
            for (int j = 0; j < nw; j++) begin
              get_word(w, early, vld);
              ew[15:0]  = pat(addr_of(xs, ys, wd, 2*j));
              ew[31:16] = (2*j + 1 < n) ? pat(addr_of(xs, ys, wd, 2*j+1)) : 16'h0;
              if (early || !vld) begin
                bad++;
                chk(0, "R6 read valid timing", {early, vld}, 2'b01);
              end
              if (w !== ew) begin
                bad++;
                chk(0, "R3 R6 R8 read word", w, ew);
              end
            end
            chk(bad == 0, "R6 read words of rectangle", bad, 0);
            chk(!busy, "R8 busy low after last read pixel", busy, 0);
          end
    wr_valid = 1'b0;
    chk(mem_miss() == 0, "R10 write words ignored in read mode", mem_miss(), 0);

    // R4 direction over every opcode
    for (int op = 0; op < 256; op++) begin
      bit is_rd;
      is_rd = (op[7:5] == 3'b110);
      do_start(8'(op), 32'h0, 32'h0001_0001);
      chk(wr_ready == !is_rd, "R4 direction from opcode", wr_ready, !is_rd);
      if (is_rd) get_word(w, early, vld);
      else begin
        send_word(32'h0, 0);
        exp_mem[0] = 16'h0;
        repeat (2) @(negedge clk);
      end
      chk(!busy, "R8 single-pixel transfer finished", busy, 0);
    end
    chk(anomaly == 0, "R9 no anomaly without overlap", anomaly, 0);

    // R9 restart while busy
    fill_pat();
    do_start(8'h20, 32'h0001_0001, 32'h0002_0002);
    send_word(32'hAAAA_BBBB, 0);
    exp_mem[1*NC + 1] = 16'hBBBB;
    exp_mem[1*NC + 2] = 16'hAAAA;
    @(negedge clk);
    do_start(8'h20, 32'h0002_0005, 32'h0001_0001);
    chk(anomaly && busy, "R9 anomaly set on restart", {anomaly, busy}, 2'b11);
    send_word(32'h1111_2222, 0);
    exp_mem[2*NC + 5] = 16'h2222;
    repeat (2) @(negedge clk);
    chk(!busy, "R9 new transfer completes", busy, 0);
    chk(anomaly, "R9 anomaly sticky", anomaly, 1);
    chk(mem_miss() == 0, "R9 old transfer aborted", mem_miss(), 0);

    do_reset();
    chk(!anomaly && !busy, "R11 reset clears anomaly", {anomaly, busy}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule